// File: doc/BRIEF.md
# OSD Display-Window Start Position Detector

This block follows the raster position of an on-screen-display overlay and decides the cycle on which a display row may begin. It runs on the OSD pixel clock. It takes the horizontal and vertical sync inputs, each with its own polarity select, and brings both into the clock domain through two flops each. A horizontal counter measures pixel clocks since the end of the last horizontal sync. A vertical counter counts horizontal syncs since the last vertical sync began.

Two 6-bit codes select the row start. The horizontal code picks a pixel offset in steps of four clocks. The vertical code picks a line in steps of four lines above a fixed base of four lines, so the largest code lands on line 256. When both counters sit on their targets and the enable is set, the block emits a one-cycle start pulse. It then holds a row-active level until the next horizontal sync. Both counters saturate instead of wrapping, so a lost sync cannot produce a second match.

The pins are control and status levels sampled every clock. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `osd_start_detect`

## Requirements
- R1: Each sync input passes through two flops before use. Polarity bit 1 makes the matching sync active-high and bit 0 makes it active-low. `hsync_pol` and `vsync_pol` act independently.
- R2: `h_count` is 0 while horizontal sync is active. It rises by one on every clock while horizontal sync is inactive.
- R3: `v_count` clears to 0 on entry into vertical-sync-active. It rises by one on each entry into horizontal-sync-active.
- R4: The horizontal target is 4*`h_start`. The vertical target is 4*`v_start`+4, so `v_start`=63 gives line 256.
- R5: With `osd_en`=1, `start_pulse` is high for exactly one cycle, the cycle after both counts equal their targets with horizontal sync inactive. In that cycle `h_count`=4*`h_start`+1 and `v_count` equals the vertical target. This happens once per line.
- R6: `row_active` rises together with `start_pulse`. It stays high until the next entry into horizontal-sync-active clears it.
- R7: While `osd_en`=0, `start_pulse` and `row_active` stay 0.
- R8: Both counters hold at 2^W-1 (1023 at default width) instead of wrapping.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | OSD pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osd_en | input | 1 | Enables start detection |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| hsync_pol | input | 1 | 1 = hsync active-high, 0 = active-low |
| vsync_pol | input | 1 | 1 = vsync active-high, 0 = active-low |
| h_start | input | 6 | Horizontal start code |
| v_start | input | 6 | Vertical start code |
| start_pulse | output | 1 | One-cycle row start |
| h_count | output | 10 | Pixel clocks since horizontal sync ended |
| v_count | output | 10 | Lines since vertical sync began |
| row_active | output | 1 | High from row start to next horizontal sync |

## Verification
A wrong sync state or a wrong counter value moves the pulse. It then arrives with `h_count` or `v_count` off target, or a frame shows zero or two pulses. This shows up within the frame being checked. A broken polarity path shows up at once, because the counts no longer clear when the sync pin is in its active level. A counter that wraps instead of saturating shows a small value after a long sync-free stretch.

// File: rtl/osd_pkg.sv
package osd_pkg;
  typedef enum int unsigned {
    SYNC_H = 0,
    SYNC_V = 1
  } sync_idx_e;
  localparam int unsigned NUM_SYNC = 2;
endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic act,
  output logic rise
);
  logic [1:0] meta;
  logic       act_q;

  // polarity-normalised level: 1 means sync is active
  assign act  = ~(meta[1] ^ pol);
  assign rise = act & ~act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta  <= '0;
      act_q <= 1'b1;   // no false edge right after reset
    end else begin
      meta  <= {meta[0], pin};
      act_q <= act;
    end
  end
endmodule

// File: rtl/osd_sat_counter.sv
module osd_sat_counter #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/osd_start_detect.sv
module osd_start_detect
  import osd_pkg::*;
#(
  parameter int unsigned POS_W   = 6,
  parameter int unsigned HCNT_W  = 10,
  parameter int unsigned VCNT_W  = 10,
  parameter int unsigned STEP_SH = 2,
  parameter int unsigned V_BASE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osd_en,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              hsync_pol,
  input  logic              vsync_pol,
  input  logic [POS_W-1:0]  h_start,
  input  logic [POS_W-1:0]  v_start,
  output logic              start_pulse,
  output logic [HCNT_W-1:0] h_count,
  output logic [VCNT_W-1:0] v_count,
  output logic              row_active
);
  localparam logic [VCNT_W-1:0] V_OFS = VCNT_W'(V_BASE);

  logic [NUM_SYNC-1:0] pins, pols, act, rise;
  assign pins = {vsync_in, hsync_in};
  assign pols = {vsync_pol, hsync_pol};

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
    osd_sync_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins[g]),
      .pol  (pols[g]),
      .act  (act[g]),
      .rise (rise[g])
    );
  end

  osd_sat_counter #(.W(HCNT_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n),
    .clr(act[SYNC_H]), .inc(1'b1), .cnt(h_count)
  );

  osd_sat_counter #(.W(VCNT_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n),
    .clr(rise[SYNC_V]), .inc(rise[SYNC_H]), .cnt(v_count)
  );

  logic [HCNT_W-1:0] h_tgt;
  logic [VCNT_W-1:0] v_tgt;
  logic              hit;

  assign h_tgt = HCNT_W'(h_start) << STEP_SH;
  assign v_tgt = (VCNT_W'(v_start) << STEP_SH) + V_OFS;
  assign hit   = osd_en && !row_active && !act[SYNC_H]
              && (h_count == h_tgt) && (v_count == v_tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      row_active  <= 1'b0;
    end else begin
      start_pulse <= hit;
      if (!osd_en || rise[SYNC_H]) row_active <= 1'b0;
      else if (hit)                row_active <= 1'b1;
    end
  end
endmodule

// File: rtl/osd_start_detect_chk.sv
module osd_start_detect_chk #(
  parameter int unsigned POS_W   = 6,
  parameter int unsigned HCNT_W  = 10,
  parameter int unsigned VCNT_W  = 10,
  parameter int unsigned STEP_SH = 2,
  parameter int unsigned V_BASE  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              osd_en,
  input logic [POS_W-1:0]  h_start,
  input logic [POS_W-1:0]  v_start,
  input logic              start_pulse,
  input logic              row_active,
  input logic [HCNT_W-1:0] h_count,
  input logic [VCNT_W-1:0] v_count
);
  localparam logic [HCNT_W-1:0] HMAX = {HCNT_W{1'b1}};
  localparam logic [VCNT_W-1:0] VMAX = {VCNT_W{1'b1}};

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R5
  AST_PULSE_H_POS: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> h_count == (HCNT_W'($past(h_start)) << STEP_SH) + 1'b1); // R5
  AST_PULSE_V_POS: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> v_count == (VCNT_W'($past(v_start)) << STEP_SH) + VCNT_W'(V_BASE)); // R4
  AST_ROW_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> row_active); // R6
  AST_EN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !osd_en |=> !start_pulse && !row_active); // R7
  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    h_count != HMAX |=> h_count == $past(h_count) + 1'b1 || h_count == '0); // R2
  AST_H_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    h_count == HMAX |=> h_count == HMAX || h_count == '0); // R8
  AST_V_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    v_count == VMAX |=> v_count == VMAX || v_count == '0); // R8
  AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    v_count != VMAX |=> $stable(v_count) || v_count == $past(v_count) + 1'b1 || v_count == '0); // R3
endmodule

bind osd_start_detect osd_start_detect_chk #(
  .POS_W(POS_W), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .STEP_SH(STEP_SH), .V_BASE(V_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .osd_en(osd_en), .h_start(h_start), .v_start(v_start),
  .start_pulse(start_pulse), .row_active(row_active), .h_count(h_count), .v_count(v_count)
);

// File: tb/osd_start_detect_bench.sv
module osd_start_detect_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, osd_en = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
  logic hsync_pol = 1'b1, vsync_pol = 1'b1;
  logic [5:0] h_start = '0, v_start = '0;
  logic start_pulse, row_active;
  logic [9:0] h_count, v_count;

  osd_start_detect u_osd_start_detect (
    .clk(clk), .rst_n(rst_n), .osd_en(osd_en), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .h_start(h_start), .v_start(v_start),
    .start_pulse(start_pulse), .h_count(h_count), .v_count(v_count), .row_active(row_active)
  );

  int total = 0, bad = 0, cycles = 0;
  bit counting = 0;
  int npulse = 0, exp_h = 0, exp_v = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one cycle: wait for the falling edge, then inspect the settled outputs
  task automatic cyc();
    @(negedge clk);
    if (counting && start_pulse) begin
      npulse++;
      chk(h_count == 10'(exp_h), "R5 h_count at pulse", h_count, exp_h);
      chk(v_count == 10'(exp_v), "R4 v_count at pulse", v_count, exp_v);
      chk(row_active, "R6 row_active at pulse", row_active, 1);
    end
    if (counting && !osd_en && (start_pulse || row_active))
      chk(0, "R7 output while disabled", {start_pulse, row_active}, 0);
  endtask

  // vector fields: hpol, vpol, en, h_start[5:0], v_start[5:0], expected pulse count[1:0]
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 6'd0,  6'd0, 2'd1},
    {1'b0, 1'b0, 1'b1, 6'd3,  6'd1, 2'd1},
    {1'b1, 1'b0, 1'b1, 6'd10, 6'd2, 2'd1},
    {1'b0, 1'b1, 1'b1, 6'd5,  6'd0, 2'd1},
    {1'b1, 1'b1, 1'b0, 6'd2,  6'd1, 2'd0},
    {1'b0, 1'b0, 1'b1, 6'd63, 6'd0, 2'd1},
    {1'b1, 1'b1, 1'b1, 6'd7,  6'd3, 2'd1},
    {1'b0, 1'b1, 1'b0, 6'd0,  6'd0, 2'd0}
  };

  task automatic run_frame(input logic hp, input logic vp, input logic en,
                           input int hs, input int vs, input int exp_n);
    int vt;
    vt = 4 * vs + 4;
    exp_h = 4 * hs + 1;
    exp_v = vt;
    hsync_pol = hp; vsync_pol = vp; osd_en = en;
    h_start = 6'(hs); v_start = 6'(vs);
    hsync_in = ~hp; vsync_in = ~vp;
    repeat (6) cyc();
    vsync_in = vp;
    repeat (3) cyc();
    vsync_in = ~vp;
    repeat (3) cyc();
    npulse = 0;
    counting = 1;
    for (int ln = 0; ln < vt + 2; ln++) begin
      hsync_in = hp;
      repeat (4) cyc();
      chk(row_active == 1'b0, "R6 row_active cleared by hsync", row_active, 0);
      chk(h_count == 10'd0, "R1 R2 h_count held at 0 in active sync", h_count, 0);
      hsync_in = ~hp;
      repeat (4 * hs + 12) cyc();
    end
    counting = 0;
    chk(npulse == exp_n, "R5 R7 pulses per frame", npulse, exp_n);
  endtask

  initial begin
    repeat (3) cyc();
    chk(!start_pulse && !row_active && h_count == 0 && v_count == 0,
        "R9 reset outputs", {start_pulse, row_active, h_count, v_count}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      run_frame(VEC[i][16], VEC[i][15], VEC[i][14], int'(VEC[i][13:8]),
                int'(VEC[i][7:2]), int'(VEC[i][1:0]));

    // R4 corner: largest vertical code lands on line 256
    run_frame(1'b1, 1'b0, 1'b1, 1, 63, 1);
    chk(exp_v == 256, "R4 max vertical code", exp_v, 256);

    // R8: horizontal counter saturates during a long sync-free stretch
    osd_en = 1'b0; hsync_pol = 1'b1; vsync_pol = 1'b1;
    hsync_in = 1'b0; vsync_in = 1'b0;
    repeat (1100) cyc();
    chk(h_count == 10'd1023, "R8 h_count saturates", h_count, 1023);

    // R8: vertical counter saturates after many short lines
    vsync_in = 1'b1; repeat (3) cyc(); vsync_in = 1'b0; repeat (3) cyc();
    for (int k = 0; k < 1100; k++) begin
      hsync_in = 1'b1; repeat (2) cyc();
      hsync_in = 1'b0; repeat (2) cyc();
    end
    chk(v_count == 10'd1023, "R8 v_count saturates", v_count, 1023);

    // R3: a vertical sync clears the line count
    vsync_in = 1'b1; repeat (4) cyc();
    chk(v_count == 10'd0, "R3 v_count cleared by vsync", v_count, 0);
    vsync_in = 1'b0; repeat (3) cyc();
    hsync_in = 1'b1; repeat (4) cyc();
    chk(v_count == 10'd1, "R3 v_count counts hsync", v_count, 1);
    hsync_in = 1'b0; repeat (10) cyc();
    chk(h_count >= 10'd6 && h_count <= 10'd9, "R2 h_count advances", h_count, 8);

    // R9: reset in mid-run
    rst_n = 1'b0; repeat (2) cyc();
    chk(h_count == 0 && v_count == 0 && !row_active && !start_pulse,
        "R9 mid-run reset", {h_count, v_count}, 0);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule